// File: doc/BRIEF.md
# Software-Clocked Serial Management Register Target

This block is the target side of a two-wire serial management link in the style of IEEE 802.3 Clause 22. The host does not drive a free-running management clock. Instead it writes a small control word in which one bit serves as the clock, one as the data line and one as the line direction. Each write that moves the clock bit from 0 to 1 advances the frame decoder by exactly one bit. Behind the decoder sits storage for 32 PHY addresses × 32 registers of 16 bits. The target accepts read and write frames and returns read data on the shared data bit. A handful of register numbers return fixed identity and status words instead of their stored contents.

The frame decoder has twelve states. RESET clears the address fields, the data word and the bit position. On a 1 it moves to IDLE, and on a 0 it moves to START. IDLE holds on 1 and goes to START on 0. START needs a 1 to reach OP, and a 0 sends it back to RESET. In OP, a 1 leads to OP_RD and a 0 leads to OP_WR. OP_RD accepts a 0 and OP_WR accepts a 1; either one then goes to PHY, and any other bit returns to RESET. PHY and REG each take five bits and then hand over to TA1. From TA1 a read goes straight to FETCH, while a write passes through TA2 into DATA. FETCH looks up the register, drives data bit 15 and enters DATA. DATA moves one bit per step, and after bit 0 it returns to RESET.

The host reads the control word back at any time. While the direction bit is clear, the data-bit position shows the target's output bit instead of the stored value.

Top module: `mdio_bitbang_target`

## Requirements
- R1: A synchronous active-high reset clears every stored register to 0 and puts the decoder in RESET. It sets the output data bit (`mdio_out`) to 1 and holds `commit_pulse` low. After reset the control readback is 0x02 (the data bit shows the output bit 1).
- R2: The decoder advances only on a control write that sets the clock bit (bit 0) to 1 while the previously written clock bit was 0. Further writes with the clock bit still 1, whatever data they carry, do not advance it.
- R3: The direction bit (bit 2) set to 1 means the host drives the line. On a step, the data bit (bit 1) is then taken as the input bit and becomes the output bit. With direction 0, the current output bit is used as the input bit. A readback returns the stored control word, except that while direction is 0 the bit-1 position shows `mdio_out`.
- R4: The decoder stays in IDLE (or moves from RESET to IDLE) on each 1. A 0 is the first start bit. The next bit must be 1; a 0 there returns the decoder to RESET and no frame is carried out.
- R5: The two opcode bits 1,0 select a read and 0,1 select a write. The patterns 1,1 and 0,0 return the decoder to RESET without any register access.
- R6: After the opcode, a 5-bit PHY address and then a 5-bit register address are shifted in, most significant bit first. Each PHY address selects its own bank of 32 registers.
- R7: A write frame takes two turnaround bits and then 16 data bits, most significant bit first. The register is written only on the step that carries data bit 0. `commit_pulse` is high for exactly the one cycle after that control write.
- R8: A read frame takes one turnaround bit. The next step fetches the register and drives data bit 15 on `mdio_out`. The following 15 steps drive bits 14 down to 0.
- R9: Reads of register 1, 2, 3, 5, 6 and 17 return 0x782C, 0x0013, 0x61D4, 0x41E1, 0x0001 and 0x4700, at any PHY address and whatever was written there.
- R10: A read of register 0 returns the stored value with bits 15 and 9 forced to 0 and bit 13 forced to 1. Every other register number returns its stored value.
- R11: After each complete frame the decoder is back in RESET. A new frame may start at once with its start bits and needs no preamble of 1s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTRL_W | Control word: bit 0 clock, bit 1 data, bit 2 direction |
| ctl_rdata | output | CTRL_W | Control word readback, data bit replaced by `mdio_out` while direction is 0 |
| mdio_out | output | 1 | Current output data bit of the target |
| commit_pulse | output | 1 | One-cycle pulse after a write frame commits |

## Verification
The hardest situation to reach is a decoder that has fallen out of step in the middle of a frame. A malformed start or opcode does not simply stop the decoder: it keeps reading the following bits as a fresh frame. Those bits can land it deep inside a phantom read. The stimulus sends the rest of a broken frame and then a long run of 1s, so that any phantom frame finishes and the decoder settles in IDLE. The bench then confirms that no commit pulse appeared and that the addressed register still reads back unchanged. Steps that the decoder must not count are tested on their own. Repeated writes with the clock bit already high and inverted data are placed inside a valid write frame. A clock edge with direction 0 and a 0 on the data bit is sent just before a frame that has no preamble. If the decoder counted either of these, the frame would be corrupted.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_START,
        ST_OP,
        ST_OP_RD,
        ST_OP_WR,
        ST_PHY,
        ST_REG,
        ST_TA1,
        ST_TA2,
        ST_FETCH,
        ST_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_ctl_port.sv
module mdio_ctl_port #(
    parameter int CTRL_W  = 8,
    parameter int CLK_BIT = 0,
    parameter int DAT_BIT = 1,
    parameter int DIR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              drv_en,
    input  logic              drv_bit,
    output logic [CTRL_W-1:0] ctl_rdata,
    output logic              step,
    output logic              bit_in,
    output logic              line_out
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              line_q;

    // rising edge of the software clock bit, judged against the last write
    assign step   = ctl_wr && !ctrl_q[CLK_BIT] && ctl_wdata[CLK_BIT];
    assign bit_in = ctl_wdata[DIR_BIT] ? ctl_wdata[DAT_BIT] : line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            line_q <= 1'b1;
        end else begin
            if (ctl_wr)
                ctrl_q <= ctl_wdata;
            if (drv_en)
                line_q <= drv_bit;
            else if (step)
                line_q <= bit_in;
        end
    end

    always_comb begin
        ctl_rdata = ctrl_q;
        if (!ctrl_q[DIR_BIT])
            ctl_rdata[DAT_BIT] = line_q;
    end

    assign line_out = line_q;

    p_line_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!step && !drv_en) |=> $stable(line_q));

    p_host_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (step && ctl_wdata[DIR_BIT] && !drv_en) |=> (line_q == $past(ctl_wdata[DAT_BIT])));

endmodule

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile #(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_val
);

    localparam int AW    = PHY_AW + REG_AW;
    localparam int DEPTH = 1 << AW;

    localparam logic [DATA_W-1:0] CTL_CLR  = DATA_W'(16'h8200);
    localparam logic [DATA_W-1:0] CTL_SET  = DATA_W'(16'h2000);
    localparam logic [DATA_W-1:0] VAL_STAT = DATA_W'(16'h782C);
    localparam logic [DATA_W-1:0] VAL_ID_H = DATA_W'(16'h0013);
    localparam logic [DATA_W-1:0] VAL_ID_L = DATA_W'(16'h61D4);
    localparam logic [DATA_W-1:0] VAL_LPA  = DATA_W'(16'h41E1);
    localparam logic [DATA_W-1:0] VAL_ANX  = DATA_W'(16'h0001);
    localparam logic [DATA_W-1:0] VAL_PSTS = DATA_W'(16'h4700);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     addr;
    logic [DATA_W-1:0] stored;

    assign addr   = {phy_addr, reg_addr};
    assign stored = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_AW'(0):  rd_val = (stored & ~CTL_CLR) | CTL_SET;
            REG_AW'(1):  rd_val = VAL_STAT;
            REG_AW'(2):  rd_val = VAL_ID_H;
            REG_AW'(3):  rd_val = VAL_ID_L;
            REG_AW'(5):  rd_val = VAL_LPA;
            REG_AW'(6):  rd_val = VAL_ANX;
            REG_AW'(17): rd_val = VAL_PSTS;
            default:     rd_val = stored;
        endcase
    end

    p_reg0_bits_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == '0) |-> (!rd_val[15] && !rd_val[9] && rd_val[13]));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_tgt_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] rd_val,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [REG_AW-1:0] reg_addr,
    output logic              drv_en,
    output logic              drv_bit,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              commit_pulse
);

    localparam int MAX_AW = (PHY_AW > REG_AW) ? PHY_AW : REG_AW;
    localparam int CNT_W  = $clog2(MAX_AW + 1);
    localparam int POS_W  = $clog2(DATA_W);
    localparam logic [POS_W-1:0] POS_TOP = POS_W'(DATA_W - 1);

    mdio_state_e       state_q, st_n;
    logic              is_rd_q, is_rd_n;
    logic [PHY_AW-1:0] phy_q, phy_n;
    logic [REG_AW-1:0] reg_q, reg_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [POS_W-1:0]  pos_q, pos_n;
    logic [DATA_W-1:0] data_q, data_n;
    logic              commit_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RESET;
            is_rd_q  <= 1'b0;
            phy_q    <= '0;
            reg_q    <= '0;
            cnt_q    <= '0;
            pos_q    <= POS_TOP;
            data_q   <= '0;
            commit_q <= 1'b0;
        end else begin
            state_q  <= st_n;
            is_rd_q  <= is_rd_n;
            phy_q    <= phy_n;
            reg_q    <= reg_n;
            cnt_q    <= cnt_n;
            pos_q    <= pos_n;
            data_q   <= data_n;
            commit_q <= wr_en;
        end
    end

    // next state and per-step outputs
    always_comb begin
        st_n    = state_q;
        is_rd_n = is_rd_q;
        phy_n   = phy_q;
        reg_n   = reg_q;
        cnt_n   = cnt_q;
        pos_n   = pos_q;
        data_n  = data_q;
        drv_en  = 1'b0;
        drv_bit = 1'b0;
        wr_en   = 1'b0;
        if (step) begin
            unique case (state_q)
                ST_RESET: begin
                    phy_n  = '0;
                    reg_n  = '0;
                    cnt_n  = '0;
                    pos_n  = POS_TOP;
                    data_n = '0;
                    st_n   = bit_in ? ST_IDLE : ST_START;
                end
                ST_IDLE:  st_n = bit_in ? ST_IDLE : ST_START;
                ST_START: st_n = bit_in ? ST_OP : ST_RESET;
                ST_OP:    st_n = bit_in ? ST_OP_RD : ST_OP_WR;
                ST_OP_RD: begin
                    if (!bit_in) begin
                        is_rd_n = 1'b1;
                        st_n    = ST_PHY;
                    end else begin
                        st_n = ST_RESET;
                    end
                end
                ST_OP_WR: begin
                    if (bit_in) begin
                        is_rd_n = 1'b0;
                        st_n    = ST_PHY;
                    end else begin
                        st_n = ST_RESET;
                    end
                end
                ST_PHY: begin
                    phy_n = {phy_q[PHY_AW-2:0], bit_in};
                    if (cnt_q == CNT_W'(PHY_AW - 1)) begin
                        cnt_n = '0;
                        st_n  = ST_REG;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                ST_REG: begin
                    reg_n = {reg_q[REG_AW-2:0], bit_in};
                    if (cnt_q == CNT_W'(REG_AW - 1)) begin
                        cnt_n = '0;
                        st_n  = ST_TA1;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                ST_TA1:   st_n = is_rd_q ? ST_FETCH : ST_TA2;
                ST_TA2:   st_n = ST_DATA;
                ST_FETCH: begin
                    drv_en  = 1'b1;
                    drv_bit = rd_val[DATA_W-1];
                    data_n  = rd_val;
                    pos_n   = POS_TOP - POS_W'(1);
                    st_n    = ST_DATA;
                end
                ST_DATA: begin
                    if (is_rd_q) begin
                        drv_en  = 1'b1;
                        drv_bit = data_q[pos_q];
                    end else begin
                        data_n[pos_q] = bit_in;
                    end
                    if (pos_q == '0) begin
                        wr_en = !is_rd_q;
                        st_n  = ST_RESET;
                    end else begin
                        pos_n = pos_q - POS_W'(1);
                    end
                end
                default: st_n = ST_RESET;
            endcase
        end
    end

    assign phy_addr     = phy_q;
    assign reg_addr     = reg_q;
    assign wr_data      = data_n;
    assign commit_pulse = commit_q;

    p_no_step_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));

    p_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && step) |=> (state_q == ST_DATA && pos_q == POS_TOP - POS_W'(1)));

    p_ta_write_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TA1 && step && !is_rd_q) |=> (state_q == ST_TA2));

    p_commit_back_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state_q == ST_RESET && commit_q));

    p_commit_single_r7: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> !commit_q);

endmodule

// File: rtl/mdio_bitbang_target.sv
module mdio_bitbang_target #(
    parameter int CTRL_W  = 8,
    parameter int CLK_BIT = 0,
    parameter int DAT_BIT = 1,
    parameter int DIR_BIT = 2,
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    output logic [CTRL_W-1:0] ctl_rdata,
    output logic              mdio_out,
    output logic              commit_pulse
);

    logic              step;
    logic              bit_in;
    logic              drv_en;
    logic              drv_bit;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_val;
    logic [PHY_AW-1:0] phy_addr;
    logic [REG_AW-1:0] reg_addr;

    mdio_ctl_port #(
        .CTRL_W (CTRL_W),
        .CLK_BIT(CLK_BIT),
        .DAT_BIT(DAT_BIT),
        .DIR_BIT(DIR_BIT)
    ) i_port (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata),
        .drv_en   (drv_en),
        .drv_bit  (drv_bit),
        .ctl_rdata(ctl_rdata),
        .step     (step),
        .bit_in   (bit_in),
        .line_out (mdio_out)
    );

    mdio_frame_fsm #(
        .PHY_AW(PHY_AW),
        .REG_AW(REG_AW),
        .DATA_W(DATA_W)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .bit_in      (bit_in),
        .rd_val      (rd_val),
        .phy_addr    (phy_addr),
        .reg_addr    (reg_addr),
        .drv_en      (drv_en),
        .drv_bit     (drv_bit),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .commit_pulse(commit_pulse)
    );

    mdio_phy_regfile #(
        .PHY_AW(PHY_AW),
        .REG_AW(REG_AW),
        .DATA_W(DATA_W)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .phy_addr(phy_addr),
        .reg_addr(reg_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_val  (rd_val)
    );

endmodule

// File: tb/test_mdio_bitbang_target.sv
module test_mdio_bitbang_target;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    // {write, phy[4:0], reg[4:0], wdata[15:0], expected read[15:0]}
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b1, 5'd3,  5'd4,  16'hBEEF, 16'h0000},
        {1'b0, 5'd3,  5'd4,  16'h0000, 16'hBEEF},
        {1'b1, 5'd3,  5'd0,  16'h8201, 16'h0000},
        {1'b0, 5'd3,  5'd0,  16'h0000, 16'h2001},
        {1'b1, 5'd7,  5'd1,  16'h1234, 16'h0000},
        {1'b0, 5'd7,  5'd1,  16'h0000, 16'h782C},
        {1'b0, 5'd0,  5'd2,  16'h0000, 16'h0013},
        {1'b0, 5'd9,  5'd3,  16'h0000, 16'h61D4},
        {1'b0, 5'd0,  5'd5,  16'h0000, 16'h41E1},
        {1'b0, 5'd0,  5'd6,  16'h0000, 16'h0001},
        {1'b0, 5'd0,  5'd17, 16'h0000, 16'h4700},
        {1'b1, 5'd31, 5'd31, 16'hA5A5, 16'h0000},
        {1'b0, 5'd31, 5'd31, 16'h0000, 16'hA5A5},
        {1'b0, 5'd30, 5'd31, 16'h0000, 16'h0000},
        {1'b0, 5'd7,  5'd4,  16'h0000, 16'h0000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       mdio_out;
    logic       commit_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int n_commit = 0;
    logic        done = 1'b0;
    logic [42:0] cur;
    logic [15:0] rv;
    logic        c_pre, c_post;
    int          base;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (!rst && commit_pulse) n_commit++;

    mdio_bitbang_target i_mdio_bitbang_target (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_rdata   (ctl_rdata),
        .mdio_out    (mdio_out),
        .commit_pulse(commit_pulse)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ctl_wr = 1'b0;
        ctl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // control word: bit2 direction, bit1 data, bit0 clock
    task automatic send_bit(input logic b, input logic dir, input logic glitch);
        ctl_write({5'b0, dir, b, 1'b0});
        ctl_write({5'b0, dir, b, 1'b1});
        if (glitch) ctl_write({5'b0, dir, ~b, 1'b1});
    endtask

    task automatic pre(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b1, 1'b0);
    endtask

    task automatic wframe(input int npre, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input logic g,
                          output logic cp, output logic cq);
        pre(npre);
        send_bit(1'b0, 1'b1, g); send_bit(1'b1, 1'b1, g);
        send_bit(1'b0, 1'b1, g); send_bit(1'b1, 1'b1, g);
        for (int i = 4; i >= 0; i--) send_bit(phy[i], 1'b1, g);
        for (int i = 4; i >= 0; i--) send_bit(rg[i], 1'b1, g);
        send_bit(1'b1, 1'b1, g); send_bit(1'b0, 1'b1, g);
        for (int i = 15; i >= 1; i--) send_bit(d[i], 1'b1, g);
        ctl_write({5'b0, 1'b1, d[0], 1'b0});
        cp = commit_pulse;
        ctl_write({5'b0, 1'b1, d[0], 1'b1});
        cq = commit_pulse;
    endtask

    task automatic rframe(input int npre, input logic [4:0] phy, input logic [4:0] rg,
                          output logic [15:0] val);
        pre(npre);
        send_bit(1'b0, 1'b1, 1'b0); send_bit(1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0); send_bit(1'b0, 1'b1, 1'b0);
        for (int i = 4; i >= 0; i--) send_bit(phy[i], 1'b1, 1'b0);
        for (int i = 4; i >= 0; i--) send_bit(rg[i], 1'b1, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        for (int i = 15; i >= 0; i--) begin
            send_bit(1'b0, 1'b0, 1'b0);
            val[i] = ctl_rdata[1];
        end
    endtask

    initial begin
        do_reset();
        // R1: reset state at the ports
        check("R1", "commit after reset", commit_pulse, 0);
        check("R1", "mdio_out after reset", mdio_out, 1);
        check("R1", "readback after reset", ctl_rdata, 8'h02);

        // R3: readback with direction set and clear, no clock edge
        ctl_write(8'h04);
        check("R3", "readback dir=1 data=0", ctl_rdata, 8'h04);
        ctl_write(8'h20);
        check("R3", "readback dir=0 shows output bit", ctl_rdata, 8'h22);
        check("R3", "output bit unchanged without edge", mdio_out, 1);

        // table walk: R6 R7 R8 R9 R10
        for (int k = 0; k < NVEC; k++) begin
            cur = VEC[k];
            if (cur[42]) begin
                wframe(2, cur[41:37], cur[36:32], cur[31:16], 1'b0, c_pre, c_post);
                check("R7", "commit before bit 0", c_pre, 0);
                check("R7", "commit after bit 0", c_post, 1);
            end else begin
                rframe(2, cur[41:37], cur[36:32], rv);
                if (cur[36:32] == 5'd0)
                    check("R10", "register 0 masking", rv, cur[15:0]);
                else if (cur[36:32] inside {5'd1, 5'd2, 5'd3, 5'd5, 5'd6, 5'd17})
                    check("R9", "fixed readback", rv, cur[15:0]);
                else
                    check("R8 R6", "read data", rv, cur[15:0]);
            end
        end

        // R2: extra writes with clock held high and inverted data are not steps
        wframe(2, 5'd2, 5'd8, 16'h3C3C, 1'b1, c_pre, c_post);
        check("R2", "glitch frame commit", c_post, 1);
        rframe(2, 5'd2, 5'd8, rv);
        check("R2", "glitch frame data", rv, 16'h3C3C);

        // R11: back-to-back write frames without preamble
        wframe(2, 5'd4, 5'd10, 16'h1111, 1'b0, c_pre, c_post);
        check("R11", "first frame commit", c_post, 1);
        wframe(0, 5'd4, 5'd11, 16'h2222, 1'b0, c_pre, c_post);
        check("R11", "second frame commit", c_post, 1);
        rframe(2, 5'd4, 5'd10, rv);
        check("R11", "first frame data", rv, 16'h1111);
        rframe(0, 5'd4, 5'd11, rv);
        check("R11", "second frame data, no preamble", rv, 16'h2222);

        // R4: broken start 0,0 followed by the rest of a write frame
        base = n_commit;
        pre(2);
        send_bit(1'b0, 1'b1, 1'b0); send_bit(1'b0, 1'b1, 1'b0);
        send_bit(1'b0, 1'b1, 1'b0); send_bit(1'b1, 1'b1, 1'b0);
        for (int i = 4; i >= 0; i--) send_bit(((5'd3 >> i) & 5'd1) != 0, 1'b1, 1'b0);
        for (int i = 4; i >= 0; i--) send_bit(((5'd4 >> i) & 5'd1) != 0, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0); send_bit(1'b0, 1'b1, 1'b0);
        pre(48);
        check("R4", "no commit after broken start", n_commit - base, 0);
        rframe(2, 5'd3, 5'd4, rv);
        check("R4", "register kept after broken start", rv, 16'hBEEF);

        // R5: illegal opcodes 1,1 and 0,0
        base = n_commit;
        pre(2);
        send_bit(1'b0, 1'b1, 1'b0); send_bit(1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0); send_bit(1'b1, 1'b1, 1'b0);
        pre(32);
        send_bit(1'b0, 1'b1, 1'b0); send_bit(1'b1, 1'b1, 1'b0);
        send_bit(1'b0, 1'b1, 1'b0); send_bit(1'b0, 1'b1, 1'b0);
        pre(32);
        check("R5", "no commit after illegal opcodes", n_commit - base, 0);
        wframe(2, 5'd5, 5'd7, 16'h0ACE, 1'b0, c_pre, c_post);
        check("R5", "valid write after illegal opcodes", c_post, 1);
        rframe(2, 5'd5, 5'd7, rv);
        check("R5", "data after illegal opcodes", rv, 16'h0ACE);

        // R3 and R1: edge with direction clear samples the output bit (1), not the data bit
        do_reset();
        send_bit(1'b0, 1'b0, 1'b0);
        wframe(0, 5'd1, 5'd9, 16'h0F0F, 1'b0, c_pre, c_post);
        check("R3", "dir=0 edge not taken as start bit", c_post, 1);
        rframe(2, 5'd1, 5'd9, rv);
        check("R3", "frame data after dir=0 edge", rv, 16'h0F0F);
        rframe(2, 5'd3, 5'd4, rv);
        check("R1", "array cleared by reset", rv, 16'h0000);
        rframe(2, 5'd31, 5'd31, rv);
        check("R1", "array cleared by reset, last entry", rv, 16'h0000);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule